// File: doc/BRIEF.md
# Thermal Shutdown Status Latch

This block gathers the over-temperature indications of four squib driver channels into sticky status bits. A host reads them over SPI. Sending the read command takes a snapshot of the status. The snapshot is shifted out on MISO during the next well-formed frame, whatever that frame's command is. The bits are cleared only when that reply frame closes, so a flag is never lost before it has actually been transmitted.

An over-temperature event that arrives after the snapshot has been taken is kept, and it is reported on a later read. The block also masks each channel's fire request with that channel's own status bit. A channel in thermal shutdown therefore cannot be switched on, and the other channels keep running untouched.

The SPI pins are sampled in the system clock domain. SCK idles low, MOSI is sampled on the rising edge, MISO changes on the falling edge, and the most significant bit goes first.

Top module: `tmp_thermal_latch`

## Requirements
- R1: A channel's status bit `thermal_stat[i]` becomes 1 on the clock after `ot_flag[i]` is seen high. It stays 1 after `ot_flag[i]` returns low.
- R2: A frame is well formed only if exactly 8 SCK rising edges occurred while CS was low. A frame with any other bit count captures nothing and clears nothing.
- R3: A well-formed frame carrying 0x7F takes a snapshot of the status bits. The next well-formed frame returns the snapshot on MISO, MSB first, as a byte with zeros in bits 7..4 and channel i in bit i. When no snapshot is waiting, the reply byte is 0x00.
- R4: Status bits that were captured are cleared when CS rises at the end of the reply frame, and not earlier. They are still set after the 0x7F frame itself.
- R5: A channel event that occurs after the snapshot and before the clear is still set after the clear.
- R6: When 0x7F follows 0x7F, the second frame returns the first snapshot, performs the clear, and then captures the status as it stands after that clear.
- R7: `fire_en[i]` equals `fire_req[i]` AND NOT `thermal_stat[i]`.
- R8: A channel's shutdown does not change the fire enable of any other channel.
- R9: After reset all status bits are 0, no snapshot is waiting, and MISO is 0 while CS is high.
- R10: A malformed frame that follows 0x7F does not use up the waiting snapshot. The next well-formed frame still returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host, 0 while deselected |
| ot_flag | input | 4 | Per-channel over-temperature indication |
| fire_req | input | 4 | Per-channel fire request from the arm/fire logic |
| fire_en | output | 4 | Per-channel gated driver enable |
| thermal_stat | output | 4 | Sticky per-channel thermal status |

## Verification
The fire gate is combinational from the registered status, so the bench checks `fire_en` one clock after it changes `fire_req`. Captures and clears happen two clocks after CS rises at the pins: one clock for the input sample register and one for the state register. The bench therefore waits six clocks after every frame before it compares `thermal_stat` with its model. MISO changes two clocks after each SCK fall, and the bench samples it four clocks after that fall, just before it raises SCK. A status bit sets on the clock after `ot_flag` goes high, and the bench holds `ot_flag` for two clocks and then waits before it reads the status.

// File: rtl/tmp_pkg.sv
package tmp_pkg;
  localparam int unsigned FRAME_W_D  = 8;
  localparam logic [7:0]  CMD_READ_D = 8'h7F;
endpackage

// File: rtl/tmp_spi_port.sv
module tmp_spi_port #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_i,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] tx_byte,
  output logic               miso,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] rx_cmd,
  output logic               cs_idle
);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam int unsigned CNT_MAX = FRAME_W + 1;

  logic               s_sck, s_cs, s_mosi, p_sck, p_cs;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic               sck_rise, sck_fall, cs_rise, cs_fall;

  assign sck_rise = s_sck & ~p_sck;
  assign sck_fall = ~s_sck & p_sck;
  assign cs_rise  = s_cs & ~p_cs;
  assign cs_fall  = ~s_cs & p_cs;

  always_comb begin
    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (cs_fall) begin
      cnt_d = '0;
      tx_d  = tx_byte;
    end else if (!s_cs) begin
      if (sck_rise) begin
        rx_d = {rx_q[FRAME_W-2:0], s_mosi};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
      end
      if (sck_fall) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      s_sck  <= 1'b0;
      s_cs   <= 1'b1;
      s_mosi <= 1'b0;
      p_sck  <= 1'b0;
      p_cs   <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      s_sck  <= sck;
      s_cs   <= cs_n;
      s_mosi <= mosi;
      p_sck  <= s_sck;
      p_cs   <= s_cs;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
    end
  end

  assign frame_ok = cs_rise && (cnt_q == CNT_W'(FRAME_W));
  assign rx_cmd   = rx_q;
  assign miso     = ~s_cs & tx_q[FRAME_W-1];
  assign cs_idle  = s_cs;
endmodule

// File: rtl/tmp_therm_core.sv
module tmp_therm_core #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned FRAME_W  = 8,
  parameter logic [7:0]  CMD_READ = 8'h7F
) (
  input  logic               clk,
  input  logic               rst_i,
  input  logic [NCH-1:0]     ot_flag,
  input  logic               frame_ok,
  input  logic [FRAME_W-1:0] rx_cmd,
  output logic [NCH-1:0]     stat,
  output logic [FRAME_W-1:0] tx_byte,
  output logic               pend
);
  logic [NCH-1:0] sticky_q, sticky_d, fresh_q, fresh_d, snap_q, snap_d;
  logic           pend_q, pend_d;
  logic [NCH-1:0] base;

  always_comb begin
    sticky_d = sticky_q | ot_flag;
    fresh_d  = fresh_q | ot_flag;
    snap_d   = snap_q;
    pend_d   = pend_q;
    base     = sticky_q | ot_flag;
    if (frame_ok) begin
      if (pend_q) begin
        base   = fresh_q | ot_flag;
        pend_d = 1'b0;
      end
      if (rx_cmd == FRAME_W'(CMD_READ)) begin
        snap_d  = base;
        pend_d  = 1'b1;
        fresh_d = '0;
      end
      sticky_d = base;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sticky_q <= '0;
      fresh_q  <= '0;
      snap_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      fresh_q  <= fresh_d;
      snap_q   <= snap_d;
      pend_q   <= pend_d;
    end
  end

  assign stat    = sticky_q;
  assign pend    = pend_q;
  assign tx_byte = pend_q ? FRAME_W'(snap_q) : '0;
endmodule

// File: rtl/tmp_fire_gate.sv
module tmp_fire_gate #(
  parameter int unsigned NCH = 4
) (
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] stat,
  output logic [NCH-1:0] en
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign en[i] = req[i] & ~stat[i];
  end
endmodule

// File: rtl/tmp_thermal_latch.sv
module tmp_thermal_latch #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned FRAME_W  = tmp_pkg::FRAME_W_D,
  parameter logic [7:0]  CMD_READ = tmp_pkg::CMD_READ_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spi_sck,
  input  logic           spi_cs_n,
  input  logic           spi_mosi,
  output logic           spi_miso,
  input  logic [NCH-1:0] ot_flag,
  input  logic [NCH-1:0] fire_req,
  output logic [NCH-1:0] fire_en,
  output logic [NCH-1:0] thermal_stat
);
  logic [1:0]         rst_q;
  logic               rst_i;
  logic               frame_ok, cs_idle, pend;
  logic [FRAME_W-1:0] rx_cmd, tx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  tmp_spi_port #(.FRAME_W(FRAME_W)) u_spi (
    .clk(clk), .rst_i(rst_i), .sck(spi_sck), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .tx_byte(tx_byte), .miso(spi_miso),
    .frame_ok(frame_ok), .rx_cmd(rx_cmd), .cs_idle(cs_idle)
  );

  tmp_therm_core #(.NCH(NCH), .FRAME_W(FRAME_W), .CMD_READ(CMD_READ)) u_core (
    .clk(clk), .rst_i(rst_i), .ot_flag(ot_flag), .frame_ok(frame_ok),
    .rx_cmd(rx_cmd), .stat(thermal_stat), .tx_byte(tx_byte), .pend(pend)
  );

  tmp_fire_gate #(.NCH(NCH)) u_gate (
    .req(fire_req), .stat(thermal_stat), .en(fire_en)
  );
endmodule

// File: rtl/tmp_thermal_latch_chk.sv
module tmp_thermal_latch_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_i,
  input logic           cs_idle,
  input logic           frame_ok,
  input logic           spi_miso,
  input logic [NCH-1:0] ot_flag,
  input logic [NCH-1:0] fire_req,
  input logic [NCH-1:0] fire_en,
  input logic [NCH-1:0] thermal_stat
);
  // R1: a seen flag is reflected in the status on the next clock
  p_flag_sets_r1: assert property (@(posedge clk) disable iff (!rst_i)
    (ot_flag != '0) |=> ((thermal_stat & $past(ot_flag)) == $past(ot_flag)));

  // R4: status bits fall only on a well-formed frame end
  p_clear_on_frame_r4: assert property (@(posedge clk) disable iff (!rst_i)
    ((~thermal_stat & $past(thermal_stat)) != '0) |-> $past(frame_ok));

  // R7: no enabled channel is in shutdown
  p_gate_blocks_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (fire_en & thermal_stat) == '0);

  // R8: healthy channels pass their request unchanged
  p_others_free_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (fire_en & ~thermal_stat) == (fire_req & ~thermal_stat));

  // R9: MISO is quiet while deselected
  p_miso_idle_r9: assert property (@(posedge clk) disable iff (!rst_i)
    cs_idle |-> !spi_miso);
endmodule

bind tmp_thermal_latch tmp_thermal_latch_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_i(rst_i), .cs_idle(cs_idle), .frame_ok(frame_ok),
  .spi_miso(spi_miso), .ot_flag(ot_flag), .fire_req(fire_req),
  .fire_en(fire_en), .thermal_stat(thermal_stat)
);

// File: tb/tmp_thermal_latch_bench.sv
module tmp_thermal_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [3:0] ot_flag = '0, fire_req = '0, fire_en, thermal_stat;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [3:0] m_sticky = '0, m_fresh = '0, m_snap = '0;
  bit         m_pend = 1'b0;

  always #10 clk = ~clk;

  tmp_thermal_latch u_tmp_thermal_latch (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .ot_flag(ot_flag),
    .fire_req(fire_req), .fire_en(fire_en), .thermal_stat(thermal_stat)
  );

  function automatic logic [7:0] exp_reply();
    return m_pend ? {4'b0, m_snap} : 8'h00;
  endfunction

  function automatic logic [3:0] exp_fire(input logic [3:0] req);
    return req & ~m_sticky;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ot(input logic [3:0] m);
    ot_flag = m;
    wait_clk(2);
    ot_flag = '0;
    m_sticky |= m;
    m_fresh  |= m;
    wait_clk(2);
  endtask

  // model update for one frame: R2 R3 R4 R5 R6 R10
  task automatic model_frame(input int nbits, input logic [7:0] cmd);
    logic [3:0] base;
    if (nbits != 8) return;
    base = m_sticky;
    if (m_pend) begin
      base   = m_fresh;
      m_pend = 1'b0;
    end
    if (cmd == 8'h7F) begin
      m_snap  = base;
      m_pend  = 1'b1;
      m_fresh = '0;
    end
    m_sticky = base;
  endtask

  task automatic frame(input int nbits, input logic [7:0] cmd, output logic [7:0] rx);
    logic [7:0] sh;
    sh = cmd;
    rx = '0;
    cs_n = 1'b0;
    wait_clk(4);
    for (int b = 0; b < nbits; b++) begin
      mosi = sh[7];
      sh = {sh[6:0], 1'b0};
      wait_clk(4);
      if (b < 8) rx = {rx[6:0], miso};
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic run_frame(input string tag, input int nbits, input logic [7:0] cmd);
    logic [7:0] rx, exp;
    exp = exp_reply();
    frame(nbits, cmd, rx);
    if (nbits == 8) check({tag, " reply"}, 32'(rx), 32'(exp));
    model_frame(nbits, cmd);
    check({tag, " status"}, 32'(thermal_stat), 32'(m_sticky));
  endtask

  task automatic check_fire(input string tag, input logic [3:0] req);
    fire_req = req;
    wait_clk(1);
    check(tag, 32'(fire_en), 32'(exp_fire(req)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'h5EED_0042));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    // R9 reset state
    check("R9 stat", 32'(thermal_stat), 32'h0);
    check("R9 miso", 32'(miso), 32'h0);
    check_fire("R9 R7 fire after reset", 4'hF);
    // R1 sticky set
    pulse_ot(4'b0101);
    check("R1 sticky", 32'(thermal_stat), 32'h5);
    // R7 R8 gating
    check_fire("R7 R8 gate", 4'hF);
    check_fire("R8 partial", 4'b0110);
    run_frame("R3 no-snapshot reply", 8, 8'h00);
    // R4 capture does not clear
    run_frame("R4 read keeps", 8, 8'h7F);
    check("R4 still set", 32'(thermal_stat), 32'h5);
    // R10 R2 malformed frames
    run_frame("R10 short frame", 7, 8'h00);
    run_frame("R2 long frame", 9, 8'h00);
    // R5 event after capture
    pulse_ot(4'b1000);
    run_frame("R3 R5 reply", 8, 8'h00);
    check("R5 kept", 32'(thermal_stat), 32'h8);
    // R6 back-to-back reads
    pulse_ot(4'b0010);
    run_frame("R6 first", 8, 8'h7F);
    run_frame("R6 second", 8, 8'h7F);
    check("R6 cleared", 32'(thermal_stat), 32'h0);
    run_frame("R6 empty snapshot", 8, 8'h00);
    // random mix
    for (int i = 0; i < 150; i++) begin
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: pulse_ot(4'($urandom_range(0, 15)));
        1: run_frame("R3 rnd read", 8, 8'h7F);
        2: run_frame("R3 rnd nop", 8, 8'h00);
        3: run_frame("R2 rnd cmd", 8, 8'($urandom_range(0, 255)));
        4: run_frame("R10 rnd bad", ($urandom_range(0, 1) == 0) ? 6 : 10, 8'h7F);
        default: check_fire("R7 rnd fire", 4'($urandom_range(0, 15)));
      endcase
    end
    frame(8, 8'h00, rx);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule